// File: doc/BRIEF.md
# Latched One-Time-Programmable ROM

The block is a 512-word by 8-bit read-only store with a clocked read path. It is meant to sit on a bus where address and data share the same wires. A falling edge on the active-low chip enable, seen at a clock edge, freezes the address in an internal register. After that the address pins may carry anything. The addressed word then moves into an output data register, which keeps it until the next chip-enable cycle. The block can therefore stand in for a pipeline stage or a small piece of synchronous logic.

The output pins are driven only when three output enables agree: two are active low and one is active high. The enables are separate from chip enable, so a word held in the data register can be presented or withheld at any time. Every cell starts at 0. When the program strobe is high during a chip-enable cycle, a mask is ORed into the addressed word. Bits can only be set and are never cleared.

Top module: `otp_latched_rom`

## Requirements
- R1: While `rst` is high, the data register clears to 0 and output drive turns off, so `dout` is high-impedance. The first read after reset returns 0 on `dout` while the enables are asserted.
- R2: The address is captured at the rising clock edge where `ce_n` is sampled low after being sampled high at the previous edge. Changes on `addr` after that edge do not affect the word returned.
- R3: The data register loads the addressed word at the second rising edge after the capture edge. It then holds that word until the next capture cycle completes.
- R4: Every word of an unprogrammed array reads as 8'h00.
- R5: `dout` is driven only when `oe1_n`=0, `oe2_n`=0 and `oe3`=1 were all sampled at the previous rising edge. For the other seven enable combinations, `dout` is high-impedance.
- R6: Output enabling does not depend on `ce_n`. A word held in the data register reappears on `dout` when the enables are asserted again during standby.
- R7: If `prog` is high at the load edge (the second edge after capture), the stored word and the data register both become the old word ORed with `pmask`.
- R8: Programming never clears a bit. A later program with a mask that has zeros where bits are already set leaves those bits at 1.
- R9: With `prog` low at the load edge, `pmask` has no effect on the array or the data register.
- R10: While `ce_n` stays high (standby), changes on `addr` cause no capture, and the held word does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip enable, active low; its falling edge starts a cycle |
| addr | input | 9 | Word address, captured at the chip-enable fall |
| oe1_n | input | 1 | Output enable, active low |
| oe2_n | input | 1 | Output enable, active low |
| oe3 | input | 1 | Output enable, active high |
| prog | input | 1 | Program strobe, tied low in normal use |
| pmask | input | 8 | Bits to set in the addressed word when programming |
| dout | output | 8 | Tri-state data output |

## Verification
The capture happens at edge E0, the clock edge that first sees `ce_n` low. The bench changes `addr` to its complement just after E0. It then samples `dout` on the falling clock edge that follows E2, the second edge after capture, when the data register has just loaded. Enable changes take effect at the following rising edge, so each enable pattern is applied on a falling edge and checked one falling edge later. The bench checks high-impedance by driving the bus with two opposite patterns and reading each back unchanged.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int OTP_ADDR_W = 9;
  localparam int OTP_DATA_W = 8;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FETCH = 2'd1,
    PH_LOAD  = 2'd2
  } otp_phase_e;
endpackage

// File: rtl/otp_addr_ctl.sv
module otp_addr_ctl
  import otp_pkg::*;
#(
  parameter int ADDR_W = OTP_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              ce_q,
  output logic [ADDR_W-1:0] addr_q,
  output otp_phase_e        phase
);
  logic fall;
  assign fall = ce_q & ~ce_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q   <= 1'b1;
      addr_q <= '0;
      phase  <= PH_IDLE;
    end else begin
      ce_q <= ce_n;
      if (fall) begin
        addr_q <= addr;
        phase  <= PH_FETCH;
      end else begin
        unique case (phase)
          PH_FETCH: phase <= PH_LOAD;
          PH_LOAD:  phase <= PH_IDLE;
          default:  phase <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array
  import otp_pkg::*;
#(
  parameter int ADDR_W = OTP_ADDR_W,
  parameter int DATA_W = OTP_DATA_W
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (wr_en) cells[waddr] <= wdata;
    if (rd_en) rdata <= cells[raddr];
  end
endmodule

// File: rtl/otp_out_stage.sv
module otp_out_stage
  import otp_pkg::*;
#(
  parameter int DATA_W = OTP_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              prog,
  input  logic [DATA_W-1:0] pmask,
  input  logic [DATA_W-1:0] rdata,
  input  logic              oe1_n,
  input  logic              oe2_n,
  input  logic              oe3,
  output logic              wr_en,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] data_q,
  output logic              oe_q,
  output wire  [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] merged;
  logic              oe_all;

  always_comb begin
    merged = rdata | (prog ? pmask : '0);
    oe_all = ~oe1_n & ~oe2_n & oe3;
  end

  assign wr_en = load & prog;
  assign wdata = merged;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      if (load) data_q <= merged;
      oe_q <= oe_all;
    end
  end

  assign dout = oe_q ? data_q : {DATA_W{1'bz}};
endmodule

// File: rtl/otp_latched_rom.sv
module otp_latched_rom
  import otp_pkg::*;
#(
  parameter int ADDR_W = OTP_ADDR_W,
  parameter int DATA_W = OTP_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              oe1_n,
  input  logic              oe2_n,
  input  logic              oe3,
  input  logic              prog,
  input  logic [DATA_W-1:0] pmask,
  output wire  [DATA_W-1:0] dout
);
  logic              ce_q;
  logic [ADDR_W-1:0] addr_q;
  otp_phase_e        phase;
  logic [DATA_W-1:0] rdata;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] data_q;
  logic              wr_en;
  logic              oe_q;

  otp_addr_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst(rst), .ce_n(ce_n), .addr(addr),
    .ce_q(ce_q), .addr_q(addr_q), .phase(phase)
  );

  otp_fuse_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rd_en(phase == PH_FETCH), .raddr(addr_q), .rdata(rdata),
    .wr_en(wr_en), .waddr(addr_q), .wdata(wdata)
  );

  otp_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .load(phase == PH_LOAD), .prog(prog),
    .pmask(pmask), .rdata(rdata), .oe1_n(oe1_n), .oe2_n(oe2_n), .oe3(oe3),
    .wr_en(wr_en), .wdata(wdata), .data_q(data_q), .oe_q(oe_q), .dout(dout)
  );
endmodule

// File: rtl/otp_rom_chk.sv
module otp_rom_chk
  import otp_pkg::*;
#(
  parameter int ADDR_W = OTP_ADDR_W,
  parameter int DATA_W = OTP_DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_n,
  input logic              ce_q,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] addr_q,
  input otp_phase_e        phase,
  input logic              prog,
  input logic [DATA_W-1:0] rdata,
  input logic [DATA_W-1:0] data_q,
  input logic              oe1_n,
  input logic              oe2_n,
  input logic              oe3,
  input logic              oe_q
);
  // R2
  addr_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (ce_q && !ce_n) |=> (addr_q == $past(addr)));

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(ce_q && !ce_n) |=> $stable(addr_q));

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_LOAD) |=> $stable(data_q));

  // R8
  one_way_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LOAD) |=> ((data_q & $past(rdata)) == $past(rdata)));

  // R9
  no_prog_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LOAD && !prog) |=> (data_q == $past(rdata)));

  // R5
  drive_gate_chk: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> $past(!oe1_n && !oe2_n && oe3));
endmodule

bind otp_latched_rom otp_rom_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .ce_q(ce_q), .addr(addr),
  .addr_q(addr_q), .phase(phase), .prog(prog), .rdata(rdata),
  .data_q(data_q), .oe1_n(oe1_n), .oe2_n(oe2_n), .oe3(oe3), .oe_q(oe_q)
);

// File: tb/sim_otp_latched_rom.sv
`timescale 1ns/1ps
module sim_otp_latched_rom;
  localparam int AW = 9;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic oe1_n = 1'b0, oe2_n = 1'b0, oe3 = 1'b1;
  logic prog = 1'b0;
  logic [DW-1:0] pmask = '0;
  logic drv_en = 1'b0;
  logic [DW-1:0] drv_pat = '0;
  wire  [DW-1:0] bus;

  logic [DW-1:0] model [N];
  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign bus = drv_en ? drv_pat : {DW{1'bz}};

  otp_latched_rom #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .ce_n(ce_n), .addr(addr),
    .oe1_n(oe1_n), .oe2_n(oe2_n), .oe3(oe3),
    .prog(prog), .pmask(pmask), .dout(bus)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_bus(input string req, input logic [DW-1:0] exp);
    check(bus === exp, req, bus, exp);
  endtask

  task automatic check_z(input string req);
    drv_pat = 8'hA5; drv_en = 1'b1; #1;
    check(bus === 8'hA5, req, bus, 8'hA5);
    drv_pat = 8'h5A; #1;
    check(bus === 8'h5A, req, bus, 8'h5A);
    drv_en = 1'b0; #1;
  endtask

  task automatic access(input logic [AW-1:0] a, input bit p, input logic [DW-1:0] m);
    @(negedge clk) ce_n = 1'b1;
    @(negedge clk) begin addr = a; ce_n = 1'b0; prog = p; pmask = m; end
    @(negedge clk) addr = ~a;
    @(negedge clk);
    @(negedge clk) begin prog = 1'b0; pmask = '0; ce_n = 1'b1; end
  endtask

  initial begin
    logic [AW-1:0] last;
    for (int i = 0; i < N; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check_z("R1 reset drive off");
    rst = 1'b0;
    @(negedge clk);
    check_bus("R1 data register cleared", 8'h00);

    // R4: blank array
    for (int a = 0; a < N; a++) begin
      access(a[AW-1:0], 1'b0, 8'h00);
      check_bus("R4 blank word", 8'h00);
    end

    // R7: first programming pass
    for (int a = 0; a < N; a++) begin
      logic [DW-1:0] m;
      m = DW'((a * 37 + 11) & 8'hFF);
      model[a] = model[a] | m;
      access(a[AW-1:0], 1'b1, m);
      check_bus("R7 program merge", model[a]);
    end

    // R2 R9: readback with scrambled address and mask present, prog low
    for (int a = 0; a < N; a++) begin
      access(a[AW-1:0], 1'b0, 8'hFF);
      check_bus("R2 R9 readback", model[a]);
    end

    // R8: second pass with different masks
    for (int a = 0; a < N; a++) begin
      logic [DW-1:0] m;
      m = DW'((a * 91 + 3) & 8'hFF);
      model[a] = model[a] | m;
      access(a[AW-1:0], 1'b1, m);
      check_bus("R8 bits only set", model[a]);
    end
    for (int a = 0; a < N; a++) begin
      access(a[AW-1:0], 1'b0, 8'h00);
      check_bus("R8 persistent", model[a]);
    end

    // R5: enable combinations
    last = 9'd300;
    access(last, 1'b0, 8'h00);
    check_bus("R3 held word", model[last]);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk) begin oe1_n = k[0]; oe2_n = k[1]; oe3 = k[2]; end
      @(negedge clk);
      if (k == 4) check_bus("R5 drive", model[last]);
      else check_z("R5 high-z");
    end

    // R6 R10: standby, address wiggle, re-enable
    @(negedge clk) begin oe1_n = 1'b0; oe2_n = 1'b0; oe3 = 1'b0; end
    for (int j = 0; j < 6; j++) @(negedge clk) addr = AW'(j * 77);
    check_z("R6 disabled in standby");
    @(negedge clk) oe3 = 1'b1;
    @(negedge clk);
    check_bus("R6 R10 held word returns", model[last]);
    for (int j = 0; j < 4; j++) @(negedge clk) addr = AW'(j * 13 + 5);
    check_bus("R10 standby no capture", model[last]);
    check_bus("R3 hold", model[last]);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule